// File: doc/BRIEF.md
# Parallel DMA Receive-Block Controller

This block sits on the device side of a 32-bit parallel bus that a host bridge drives at 100 MHz. The host asks to push a block of words by pulling one of its active-low request lines low. When transfers are globally enabled, the controller answers with a one-cycle acknowledge on the matching channel. After a fixed turnaround it then samples exactly one block of words, one per rising edge.

Each block is either all payload or starts with a four-word in-band header. The header holds a magic marker, a 32-bit timestamp and two filler words. The controller removes the header and forwards the payload words with a valid strobe. It presents the timestamp on its own output with a one-cycle strobe. A block whose marker is wrong sets a sticky error flag, and its payload is dropped. The controller still consumes the whole block, so it stays aligned with the host. Between blocks the bus may float or carry junk, and none of it is forwarded.

Top module: `dma_rx_block_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge (synchronous reset), all outputs go to zero on that edge: `ack`, `pay_valid`, `stamp_valid`, `hdr_err`, `pay_data` and `stamp`. A later reset clears a set `hdr_err`.
- R2: In idle, with `xfer_en` high and at least one bit of `req_n` low, the controller raises `ack` one cycle after the edge that sampled the request. `ack` is one-hot: bit i answers bit i of `req_n`. When several channels request at once, the lowest index wins.
- R3: `ack` stays high for exactly one clock cycle per granted request.
- R4: While `xfer_en` is low, a low request is ignored and `ack` stays zero. A request that is still held when `xfer_en` rises is then acknowledged.
- R5: The host releases its request and presents word 0 two edges after the edge at which it first sees `ack` high. The controller samples word 0 on the fourth rising edge after `ack` rises, and the following words on consecutive edges.
- R6: With the metadata mode off, all 512 words of a block are forwarded in order. Each word appears on `pay_data` with `pay_valid` high in the cycle after its sampling edge.
- R7: With the metadata mode on, the first four words form a header and are not forwarded. Header word 0 is the marker 0x12341234, word 1 is the timestamp, word 2 is all zeros and word 3 is all ones. Word 1 appears on `stamp` with a one-cycle `stamp_valid` pulse. The remaining 508 words are forwarded as in R6.
- R8: If header word 0 differs from the marker, `hdr_err` rises and stays high until reset. No timestamp and no payload of that block is forwarded. The full 512 words are still consumed, so the next block is handled normally.
- R9: Requests raised while a block is in progress are ignored, with no `ack` until the block ends. Bus data outside a block is never forwarded.
- R10: The metadata mode is taken from `meta_en` at the grant. The mode holds for the whole block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising-edge sampled |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_en | input | 1 | Global enable for starting transfers |
| meta_en | input | 1 | Blocks carry a four-word header when high |
| req_n | input | NUM_CH | Active-low per-channel transfer requests |
| bus_data | input | DATA_W | Shared parallel data bus |
| ack | output | NUM_CH | One-cycle per-channel acknowledge |
| pay_data | output | DATA_W | Forwarded payload word |
| pay_valid | output | 1 | `pay_data` holds a payload word this cycle |
| stamp | output | DATA_W | Timestamp taken from the latest good header |
| stamp_valid | output | 1 | One-cycle strobe when `stamp` is updated |
| hdr_err | output | 1 | Sticky flag for a block with a wrong marker |

## Verification
The hardest situation to reach from the ports is a request that arrives while a block is being sampled. The request must stay unanswered, and the answer must not leak out once the block ends. The bench pulls the other channel's request low in the middle of a payload stream and releases it before the last word. It counts every `ack` seen during the block. A second hard case is a simultaneous request on both channels. There the bench holds the losing request only until the winner's turnaround ends. A grant to the loser would then show up as a stray acknowledge or as an unexpected payload in the scoreboard.

// File: rtl/dma_rx_pkg.sv
// Package: shared types and constants for the receive-block controller.
// Assumes a 32-bit marker is wide enough for any DATA_W used at the top.
package dma_rx_pkg;

    // Controller phases: waiting, turnaround after grant, sampling a block.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TURN    = 2'd1,
        ST_CAPTURE = 2'd2
    } rx_state_e;

    // Default header marker and header length in words.
    localparam logic [31:0] DEF_MAGIC = 32'h1234_1234;
    localparam int          HDR_WORDS = 4;
    localparam int          HDR_IDX_MAGIC = 0;
    localparam int          HDR_IDX_STAMP = 1;

endpackage

// File: rtl/dma_rx_req_arbiter.sv
// Module: fixed-priority request picker.
// Picks the lowest-index channel whose active-low request is low.
// Reports a start only while the global enable is high.
// Purely combinational; assumes the requests are synchronous to the bus clock.
module dma_rx_req_arbiter #(
    parameter int NUM_CH = 2
) (
    input  logic [NUM_CH-1:0] req_n,
    input  logic              enable,
    output logic              start,
    output logic [NUM_CH-1:0] grant
);

    logic hit;

    // Scan from channel 0 upwards; the first active request wins.
    always_comb begin
        hit   = 1'b0;
        grant = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (!req_n[i] && !hit) begin
                grant[i] = 1'b1;
                hit      = 1'b1;
            end
        end
        start = enable && hit;
    end

endmodule

// File: rtl/dma_rx_handshake_fsm.sv
// Module: handshake and block sequencer.
// Issues a one-cycle acknowledge, waits the fixed turnaround, then walks a word
// index over exactly BLOCK_WORDS sampling edges. The host must present word 0
// TURNAROUND edges after the edge at which it sees the acknowledge.
// Requests are not looked at outside the idle phase.
module dma_rx_handshake_fsm
    import dma_rx_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int BLOCK_WORDS = 512,
    parameter int TURNAROUND  = 2,
    parameter int IDX_W       = $clog2(BLOCK_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NUM_CH-1:0] grant,
    output logic [NUM_CH-1:0] ack,
    output rx_state_e         state,
    output logic [IDX_W-1:0]  word_idx,
    output logic              launch,
    output logic              word_en
);

    localparam int               TCW       = $clog2(TURNAROUND + 2);
    localparam logic [TCW-1:0]   TURN_LAST = TCW'(TURNAROUND);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(BLOCK_WORDS - 1);

    logic [TCW-1:0] tcnt;

    assign launch  = (state == ST_IDLE) && start;
    assign word_en = (state == ST_CAPTURE);

    // Phase register, acknowledge pulse, turnaround and word counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            ack      <= '0;
            tcnt     <= '0;
            word_idx <= '0;
        end else begin
            ack <= '0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        ack   <= grant;
                        state <= ST_TURN;
                        tcnt  <= '0;
                    end
                end
                ST_TURN: begin
                    if (tcnt == TURN_LAST) begin
                        state    <= ST_CAPTURE;
                        word_idx <= '0;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                    end
                end
                ST_CAPTURE: begin
                    word_idx <= word_idx + 1'b1;
                    if (word_idx == LAST_IDX) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_ACK_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack) |=> (ack == '0)); // R3

    AST_BLOCK_RUNS_TO_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE && word_idx != LAST_IDX) |=> (state == ST_CAPTURE)); // R8

    AST_NO_ACK_MID_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CAPTURE) |=> (ack == '0)); // R9

endmodule

// File: rtl/dma_rx_header_filter.sv
// Module: header stripper and payload forwarder.
// Latches the metadata mode at each grant. In metadata mode it checks header
// word 0 against the marker, captures the timestamp from word 1 and drops
// words 0..3. It forwards the rest unless the marker was wrong.
// Assumes word_en and word_idx come from the sequencer, one sampled word per cycle.
module dma_rx_header_filter
    import dma_rx_pkg::*;
#(
    parameter int          DATA_W = 32,
    parameter int          IDX_W  = 9,
    parameter logic [31:0] MAGIC  = DEF_MAGIC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              meta_en,
    input  logic              word_en,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] pay_data,
    output logic              pay_valid,
    output logic [DATA_W-1:0] stamp,
    output logic              stamp_valid,
    output logic              hdr_err
);

    localparam logic [IDX_W-1:0]  HDR_END   = IDX_W'(HDR_WORDS);
    localparam logic [IDX_W-1:0]  IDX_MAGIC = IDX_W'(HDR_IDX_MAGIC);
    localparam logic [IDX_W-1:0]  IDX_STAMP = IDX_W'(HDR_IDX_STAMP);
    localparam logic [DATA_W-1:0] MAGIC_W   = DATA_W'(MAGIC);

    logic meta_q;
    logic bad_q;
    logic in_hdr;

    assign in_hdr = meta_q && (word_idx < HDR_END);

    // Per-block mode latch and bad-marker flag, both renewed at each grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            bad_q  <= 1'b0;
        end else if (launch) begin
            meta_q <= meta_en;
            bad_q  <= 1'b0;
        end else if (word_en && in_hdr && word_idx == IDX_MAGIC && bus_data != MAGIC_W) begin
            bad_q <= 1'b1;
        end
    end

    // Sticky header error, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_err <= 1'b0;
        end else if (word_en && in_hdr && word_idx == IDX_MAGIC && bus_data != MAGIC_W) begin
            hdr_err <= 1'b1;
        end
    end

    // Timestamp capture from a header whose marker matched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stamp       <= '0;
            stamp_valid <= 1'b0;
        end else begin
            stamp_valid <= 1'b0;
            if (word_en && in_hdr && word_idx == IDX_STAMP && !bad_q) begin
                stamp       <= bus_data;
                stamp_valid <= 1'b1;
            end
        end
    end

    // Payload forwarding for every non-header word of a good block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pay_data  <= '0;
            pay_valid <= 1'b0;
        end else begin
            pay_valid <= 1'b0;
            if (word_en && !in_hdr && !bad_q) begin
                pay_data  <= bus_data;
                pay_valid <= 1'b1;
            end
        end
    end

    AST_HDR_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_err |=> hdr_err); // R8

    AST_STAMP_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_valid |=> !stamp_valid); // R7

    AST_PAY_ONLY_FROM_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> $past(word_en)); // R9

    AST_NO_PAY_AFTER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_q && !launch) |=> !pay_valid); // R8

endmodule

// File: rtl/dma_rx_block_ctrl.sv
// Module: top of the parallel DMA receive-block controller.
// Connects the request picker, the handshake sequencer and the header filter.
// Assumes every input is synchronous to clk and that the host keeps to the
// turnaround set by TURNAROUND.
module dma_rx_block_ctrl
    import dma_rx_pkg::*;
#(
    parameter int          NUM_CH      = 2,
    parameter int          DATA_W      = 32,
    parameter int          BLOCK_WORDS = 512,
    parameter int          TURNAROUND  = 2,
    parameter logic [31:0] MAGIC       = DEF_MAGIC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_en,
    input  logic              meta_en,
    input  logic [NUM_CH-1:0] req_n,
    input  logic [DATA_W-1:0] bus_data,
    output logic [NUM_CH-1:0] ack,
    output logic [DATA_W-1:0] pay_data,
    output logic              pay_valid,
    output logic [DATA_W-1:0] stamp,
    output logic              stamp_valid,
    output logic              hdr_err
);

    localparam int IDX_W = $clog2(BLOCK_WORDS);

    logic              start;
    logic [NUM_CH-1:0] grant;
    rx_state_e         state;
    logic [IDX_W-1:0]  word_idx;
    logic              launch;
    logic              word_en;

    dma_rx_req_arbiter #(
        .NUM_CH (NUM_CH)
    ) arb_i (
        .req_n  (req_n),
        .enable (xfer_en),
        .start  (start),
        .grant  (grant)
    );

    dma_rx_handshake_fsm #(
        .NUM_CH      (NUM_CH),
        .BLOCK_WORDS (BLOCK_WORDS),
        .TURNAROUND  (TURNAROUND),
        .IDX_W       (IDX_W)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .grant    (grant),
        .ack      (ack),
        .state    (state),
        .word_idx (word_idx),
        .launch   (launch),
        .word_en  (word_en)
    );

    dma_rx_header_filter #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .MAGIC  (MAGIC)
    ) flt_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .meta_en     (meta_en),
        .word_en     (word_en),
        .word_idx    (word_idx),
        .bus_data    (bus_data),
        .pay_data    (pay_data),
        .pay_valid   (pay_valid),
        .stamp       (stamp),
        .stamp_valid (stamp_valid),
        .hdr_err     (hdr_err)
    );

    AST_ACK_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack)); // R2

    AST_ACK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack) |-> $past(xfer_en)); // R4

    AST_ACK_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack) |-> ((ack & ~$past(req_n)) == ack)); // R2

    AST_PAY_NOT_IN_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TURN) |=> !pay_valid); // R5

endmodule

// File: tb/dma_rx_block_ctrl_tb.sv
// Bench: a scoreboard for the receive-block controller. The host driver task
// pushes the expected payload and timestamps into queues. A monitor pops them
// and compares them against the outputs at each falling edge.
module dma_rx_block_ctrl_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          NUM_CH     = 2;
    localparam int          BW         = 512;
    localparam logic [31:0] MAGIC      = 32'h1234_1234;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              xfer_en = 1'b0;
    logic              meta_en = 1'b0;
    logic [NUM_CH-1:0] req_n = '1;
    logic [31:0]       bus_data = '0;
    logic [NUM_CH-1:0] ack;
    logic [31:0]       pay_data;
    logic              pay_valid;
    logic [31:0]       stamp;
    logic              stamp_valid;
    logic              hdr_err;

    int          checks = 0;
    int          fails = 0;
    int          cnt = 0;
    int          stray_ack = 0;
    bit          watch_ack = 1'b0;
    bit          done = 1'b0;
    logic [31:0] tstamp = 32'd80;
    logic [31:0] exp_q[$];
    logic [31:0] stamp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_rx_block_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_en     (xfer_en),
        .meta_en     (meta_en),
        .req_n       (req_n),
        .bus_data    (bus_data),
        .ack         (ack),
        .pay_data    (pay_data),
        .pay_valid   (pay_valid),
        .stamp       (stamp),
        .stamp_valid (stamp_valid),
        .hdr_err     (hdr_err)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // Monitor: scoreboard comparison of payload and timestamps, plus stray acks.
    always @(negedge clk) begin : mon
        logic [31:0] e;
        if (rst_n) begin
            if (pay_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected payload word", pay_data, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    chk(pay_data == e, "R5 R6 payload word", pay_data, e);
                end
            end
            if (stamp_valid) begin
                if (stamp_q.size() == 0) begin
                    chk(1'b0, "R8 unexpected timestamp", stamp, 32'h0);
                end else begin
                    e = stamp_q.pop_front();
                    chk(stamp == e, "R7 timestamp", stamp, e);
                end
            end
            if (watch_ack && ack != '0) stray_ack++;
        end
    end

    // Host driver: request, handshake, optional header, payload, idle gap.
    task automatic send_block(input int ch, input bit meta, input bit good,
                              input bit poke_other, input bit both_req);
        int          t;
        logic [31:0] hw[4];
        logic [15:0] c16;
        logic [31:0] w;
        int          n;
        @(posedge clk); #1;
        meta_en = meta;
        req_n[ch] = 1'b0;
        if (both_req) req_n[1-ch] = 1'b0;
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (ack == '0 && t < 200);
        chk(ack == NUM_CH'(1 << ch), "R2 ack on requesting channel", 32'(ack), 32'(1 << ch));
        @(posedge clk);
        @(negedge clk);
        chk(ack == '0, "R3 ack lasts one cycle", 32'(ack), 32'h0);
        @(posedge clk);
        @(posedge clk); #1;
        req_n = '1;
        meta_en = ~meta;             // R10: mode change after grant must not matter
        stray_ack = 0;
        watch_ack = 1'b1;
        hw[0] = good ? MAGIC : 32'hDEAD_BEEF;
        hw[1] = tstamp;
        hw[2] = 32'h0000_0000;
        hw[3] = 32'hFFFF_FFFF;
        if (meta) begin
            if (good) stamp_q.push_back(tstamp);
            tstamp = tstamp + 32'd1016;
            for (int i = 0; i < 4; i++) begin
                bus_data = hw[i];
                @(posedge clk); #1;
            end
        end
        n = meta ? BW - 4 : BW;
        for (int i = 0; i < n; i++) begin
            c16 = 16'(cnt);
            w = {c16, 16'h0 - c16};
            bus_data = w;
            if (!meta || good) exp_q.push_back(w);
            cnt = (cnt + 1) % 2048;
            if (poke_other && i == 100) req_n[1-ch] = 1'b0;
            if (poke_other && i == 200) req_n[1-ch] = 1'b1;
            @(posedge clk); #1;
        end
        bus_data = 32'hZZZZ_ZZZZ ^ 32'h0;
        for (int i = 0; i < 10; i++) begin
            bus_data = $urandom;
            @(posedge clk); #1;
        end
        watch_ack = 1'b0;
        if (poke_other) chk(stray_ack == 0, "R9 no ack during block", 32'(stray_ack), 32'h0);
        if (both_req) chk(stray_ack == 0, "R2 losing channel not granted", 32'(stray_ack), 32'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        int acks_seen;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(ack == '0 && !pay_valid && !stamp_valid && !hdr_err, "R1 outputs after reset",
            {ack, pay_valid, stamp_valid, hdr_err}, 32'h0);
        chk(pay_data == '0 && stamp == '0, "R1 data outputs after reset", pay_data | stamp, 32'h0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R4: request while disabled is ignored.
        req_n[0] = 1'b0;
        acks_seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ack != '0) acks_seen++;
        end
        chk(acks_seen == 0, "R4 no ack while disabled", 32'(acks_seen), 32'h0);
        xfer_en = 1'b1;
        send_block(0, 1'b0, 1'b1, 1'b0, 1'b0);          // R4 R5 R6 R10 plain block

        send_block(1, 1'b1, 1'b1, 1'b0, 1'b0);          // R7 header block on channel 1
        send_block(0, 1'b0, 1'b1, 1'b1, 1'b0);          // R9 request mid-block
        send_block(0, 1'b1, 1'b1, 1'b0, 1'b1);          // R2 priority with both requesting
        chk(hdr_err == 1'b0, "R7 good marker leaves no error", 32'(hdr_err), 32'h0);

        send_block(0, 1'b1, 1'b0, 1'b0, 1'b0);          // R8 wrong marker
        @(negedge clk);
        chk(hdr_err == 1'b1, "R8 error raised by wrong marker", 32'(hdr_err), 32'h1);
        send_block(1, 1'b1, 1'b1, 1'b0, 1'b0);          // R8 next block still good
        @(negedge clk);
        chk(hdr_err == 1'b1, "R8 error stays sticky", 32'(hdr_err), 32'h1);

        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R6 all payload delivered", 32'(exp_q.size()), 32'h0);
        chk(stamp_q.size() == 0, "R7 all timestamps delivered", 32'(stamp_q.size()), 32'h0);

        @(posedge clk); #1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        @(negedge clk);
        chk(hdr_err == 1'b0, "R1 reset clears header error", 32'(hdr_err), 32'h0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule